// File: doc/BRIEF.md
# Four-Level Long-Format Page Table Walker

This block translates a 48-bit virtual address by walking 64-bit long-format page tables that use a 4 KB granule. It starts at a caller-chosen lookup level (0 to 3) and a table base. At each level it forms the descriptor address from the current table base and nine bits of the virtual address. It issues one 64-bit read over a request/response memory interface and classifies the returned entry as a pointer to the next table, a block, a page or an invalid entry. The class depends on both the low two code bits and the current level.

While descending, the walker collects the restrictions carried in table pointers: no-execute, privileged no-execute, read-only, no-user-access and a non-secure marker. These restrictions only ever get stricter, and they are merged into the leaf's own permissions. A walk ends in exactly one single-cycle pulse. That pulse is either a fill record for a translation cache (output address, leaf level, access permissions, execute-never flags, contiguous hint, non-global flag, secure flag, shareability, attribute index) or a fault that carries the level where the walk stopped.

Top module: `ptw_long4k`

## Requirements
- R1: At level L the descriptor read address is the table base OR (VA[s+8:s] << 3), where s = 12 + 9*(3-L). A table pointer supplies the next base as its bits [47:12] with bits [11:0] zero. While a request waits for ready, its address is held stable.
- R2: Code bits [1:0] == 3 decode as a table pointer at levels 0 to 2. At level 3 the same code decodes as a page. A table pointer moves the walk down one level.
- R3: Code 1 is a block only at levels 1 and 2. Code 1 at levels 0 and 3, and codes 0 and 2 at any level, give a translation fault (fault_af_o = 0) whose fault_lvl_o is that level.
- R4: The fill output address is descriptor bits [47:n] joined to VA bits [n-1:0], with n = 30 at level 1, 21 at level 2 and 12 at level 3. fill_lvl_o reports the leaf level.
- R5: fill_ap_o[1] is read-only (leaf bit 7 OR any table bit 62 seen). fill_ap_o[0] is user access (leaf bit 6 AND NOT any table bit 61 seen). fill_xn_o is leaf bit 54 OR any table bit 60. fill_pxn_o is leaf bit 53 OR any table bit 59.
- R6: fill_secure_o is 1 only when secure_i was 1 at start, no table pointer on the path had bit 63 set, and leaf bit 5 is 0.
- R7: fill_ng_o equals leaf bit 11, except that it is forced to 0 when high_el_i was 1 at start.
- R8: A block or page with bit 10 (access flag) clear gives a fault with fault_af_o = 1 and the leaf level, and no fill.
- R9: Each accepted walk produces exactly one single-cycle pulse on fill_valid_o or fault_valid_o, never both. busy_o is low in that cycle. start_i is ignored while busy_o is high.
- R10: The walk begins at start_lvl_i. A walk that starts at level 3 makes exactly one read.
- R11: After reset, busy_o, mem_req_valid_o, fill_valid_o and fault_valid_o are low.
- R12: fill_sh_o = leaf bits [9:8], fill_attr_o = leaf bits [4:2], fill_contig_o = leaf bit 52.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| start_lvl_i | input | 2 | First lookup level |
| va_i | input | 48 | Virtual address to translate |
| tbl_base_i | input | 48 | First table base; bits [11:0] ignored |
| secure_i | input | 1 | Walk performed for a secure lookup |
| high_el_i | input | 1 | Walk for the two highest privilege levels |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Descriptor read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 48 | Descriptor byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Descriptor read data |
| fill_valid_o | output | 1 | Fill record pulse |
| fill_oa_o | output | 48 | Translated output address |
| fill_lvl_o | output | 2 | Leaf level (1 = 1 GB, 2 = 2 MB, 3 = 4 KB) |
| fill_ap_o | output | 2 | {read-only, user access} |
| fill_xn_o | output | 1 | Execute never |
| fill_pxn_o | output | 1 | Privileged execute never |
| fill_contig_o | output | 1 | Contiguous hint |
| fill_ng_o | output | 1 | Non-global |
| fill_secure_o | output | 1 | Targets secure address space |
| fill_sh_o | output | 2 | Shareability |
| fill_attr_o | output | 3 | Memory attribute index |
| fault_valid_o | output | 1 | Fault pulse |
| fault_af_o | output | 1 | 1 = access-flag fault, 0 = translation fault |
| fault_lvl_o | output | 2 | Level at which the walk faulted |

## Verification
The bench targets three kinds of level-dependent decode: a block code at level 0 and at level 3, the reserved codes, and a walk that starts at level 3. A decoder that ignores the level would return a fill where a fault is due, or report the wrong fault level. Restriction merging is checked with table bits that tighten a permissive leaf, and with a non-secure marker on a middle table. A design that reads only the leaf would return a writable, executable or secure mapping. Further checks cover an access-flag-clear leaf, the forced-global case, output-address splicing at all three leaf sizes, and a second start pulse during a walk. A second start must not restart the walk or add a pulse, and the random walks with stalled requests would show any address that drifts before ready.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W    = 48;
  localparam int unsigned PA_W    = 48;
  localparam int unsigned DESC_W  = 64;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned IDX_W   = 9;
  localparam int unsigned GRAN_SH = 12;

  typedef enum logic [1:0] {
    K_INV   = 2'd0,
    K_TABLE = 2'd1,
    K_BLOCK = 2'd2,
    K_PAGE  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/ptw_idx_gen.sv
module ptw_idx_gen #(
  parameter int unsigned VA_W    = ptw_pkg::VA_W,
  parameter int unsigned PA_W    = ptw_pkg::PA_W,
  parameter int unsigned LVL_W   = ptw_pkg::LVL_W,
  parameter int unsigned IDX_W   = ptw_pkg::IDX_W,
  parameter int unsigned GRAN_SH = ptw_pkg::GRAN_SH
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [PA_W-1:0]  addr_o
);
  localparam int unsigned NUM_LVL = 1 << LVL_W;
  localparam int unsigned ENT_SH  = 3;

  logic [IDX_W-1:0] idx_tab [NUM_LVL];

  // one VA slice per level, highest slice for level 0
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_idx
    localparam int unsigned LO = GRAN_SH + IDX_W * (NUM_LVL - 1 - g);
    assign idx_tab[g] = va_i[LO+IDX_W-1:LO];
  end

  assign addr_o = base_i | (PA_W'(idx_tab[lvl_i]) << ENT_SH);
endmodule

// File: rtl/ptw_desc_dec.sv
module ptw_desc_dec #(
  parameter int unsigned VA_W    = ptw_pkg::VA_W,
  parameter int unsigned PA_W    = ptw_pkg::PA_W,
  parameter int unsigned LVL_W   = ptw_pkg::LVL_W,
  parameter int unsigned IDX_W   = ptw_pkg::IDX_W,
  parameter int unsigned GRAN_SH = ptw_pkg::GRAN_SH
) (
  input  logic [1:0]       code_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [PA_W-1:0]  oa_hi_i,
  input  logic [VA_W-1:0]  va_i,
  output ptw_pkg::kind_e   kind_o,
  output logic [PA_W-1:0]  oa_o
);
  import ptw_pkg::*;
  localparam logic [LVL_W-1:0] LAST_LVL = {LVL_W{1'b1}};
  localparam int unsigned      LAST_INT = (1 << LVL_W) - 1;

  logic [PA_W-1:0] mask;
  int unsigned     off;

  always_comb begin
    unique case (code_i)
      2'b11:   kind_o = (lvl_i == LAST_LVL) ? K_PAGE : K_TABLE;
      2'b01:   kind_o = (lvl_i == LVL_W'(1) || lvl_i == LVL_W'(2)) ? K_BLOCK : K_INV;
      default: kind_o = K_INV;
    endcase
  end

  // offset width shrinks by one index stride per level
  always_comb begin
    off  = GRAN_SH + IDX_W * (LAST_INT - int'(lvl_i));
    mask = ~({PA_W{1'b1}} << off);
    oa_o = (oa_hi_i & ~mask) | (PA_W'(va_i) & mask);
  end
endmodule

// File: rtl/ptw_restrict_acc.sv
module ptw_restrict_acc (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic       ns_tbl_i,
  input  logic [1:0] ap_tbl_i,
  input  logic       xn_tbl_i,
  input  logic       pxn_tbl_i,
  output logic       ns_o,
  output logic       ro_o,
  output logic       nouser_o,
  output logic       xn_o,
  output logic       pxn_o
);
  logic [4:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (upd_i)  acc_q <= acc_q | {ns_tbl_i, ap_tbl_i[1], ap_tbl_i[0], xn_tbl_i, pxn_tbl_i};
  end

  assign {ns_o, ro_o, nouser_o, xn_o, pxn_o} = acc_q;

  // restrictions only tighten within a walk
  assert_xn_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xn_o && !clr_i) |=> xn_o);
  assert_ro_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ro_o && !clr_i) |=> ro_o);
  assert_ns_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_o && !clr_i) |=> ns_o);
endmodule

// File: rtl/ptw_long4k.sv
module ptw_long4k #(
  parameter int unsigned VA_W    = ptw_pkg::VA_W,
  parameter int unsigned PA_W    = ptw_pkg::PA_W,
  parameter int unsigned DESC_W  = ptw_pkg::DESC_W,
  parameter int unsigned LVL_W   = ptw_pkg::LVL_W,
  parameter int unsigned IDX_W   = ptw_pkg::IDX_W,
  parameter int unsigned GRAN_SH = ptw_pkg::GRAN_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LVL_W-1:0]  start_lvl_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [PA_W-1:0]   tbl_base_i,
  input  logic              secure_i,
  input  logic              high_el_i,
  output logic              busy_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DESC_W-1:0] mem_rsp_data_i,
  output logic              fill_valid_o,
  output logic [PA_W-1:0]   fill_oa_o,
  output logic [LVL_W-1:0]  fill_lvl_o,
  output logic [1:0]        fill_ap_o,
  output logic              fill_xn_o,
  output logic              fill_pxn_o,
  output logic              fill_contig_o,
  output logic              fill_ng_o,
  output logic              fill_secure_o,
  output logic [1:0]        fill_sh_o,
  output logic [2:0]        fill_attr_o,
  output logic              fault_valid_o,
  output logic              fault_af_o,
  output logic [LVL_W-1:0]  fault_lvl_o
);
  import ptw_pkg::*;

  state_e            state_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   base_q;
  logic              secure_q, high_el_q;

  kind_e             kind;
  logic [PA_W-1:0]   leaf_oa, next_base;
  logic              accept, rsp_ok, tbl_step;
  logic              acc_ns, acc_ro, acc_nouser, acc_xn, acc_pxn;
  logic [DESC_W-1:0] d;
  logic              unused_bits;

  assign d           = mem_rsp_data_i;
  assign accept      = (state_q == S_IDLE) && start_i;
  assign rsp_ok      = (state_q == S_WAIT) && mem_rsp_valid_i;
  assign tbl_step    = rsp_ok && (kind == K_TABLE);
  assign next_base   = {d[PA_W-1:GRAN_SH], {GRAN_SH{1'b0}}};
  assign unused_bits = ^{d[58:55], d[51:PA_W], tbl_base_i[GRAN_SH-1:0]};

  assign busy_o          = (state_q != S_IDLE);
  assign mem_req_valid_o = (state_q == S_REQ);

  ptw_idx_gen #(.VA_W(VA_W), .PA_W(PA_W), .LVL_W(LVL_W), .IDX_W(IDX_W), .GRAN_SH(GRAN_SH))
  u_idx (
    .base_i (base_q),
    .va_i   (va_q),
    .lvl_i  (lvl_q),
    .addr_o (mem_req_addr_o)
  );

  ptw_desc_dec #(.VA_W(VA_W), .PA_W(PA_W), .LVL_W(LVL_W), .IDX_W(IDX_W), .GRAN_SH(GRAN_SH))
  u_dec (
    .code_i  (d[1:0]),
    .lvl_i   (lvl_q),
    .oa_hi_i (d[PA_W-1:0]),
    .va_i    (va_q),
    .kind_o  (kind),
    .oa_o    (leaf_oa)
  );

  ptw_restrict_acc u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .upd_i     (tbl_step),
    .ns_tbl_i  (d[63]),
    .ap_tbl_i  (d[62:61]),
    .xn_tbl_i  (d[60]),
    .pxn_tbl_i (d[59]),
    .ns_o      (acc_ns),
    .ro_o      (acc_ro),
    .nouser_o  (acc_nouser),
    .xn_o      (acc_xn),
    .pxn_o     (acc_pxn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      lvl_q     <= '0;
      va_q      <= '0;
      base_q    <= '0;
      secure_q  <= 1'b0;
      high_el_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q   <= S_REQ;
          lvl_q     <= start_lvl_i;
          va_q      <= va_i;
          base_q    <= {tbl_base_i[PA_W-1:GRAN_SH], {GRAN_SH{1'b0}}};
          secure_q  <= secure_i;
          high_el_q <= high_el_i;
        end
        S_REQ: if (mem_req_ready_i) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          if (kind == K_TABLE) begin
            state_q <= S_REQ;
            base_q  <= next_base;
            lvl_q   <= lvl_q + LVL_W'(1);
          end else begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // result registers: one pulse per walk
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_valid_o  <= 1'b0;
      fault_valid_o <= 1'b0;
      fault_af_o    <= 1'b0;
      fault_lvl_o   <= '0;
      fill_oa_o     <= '0;
      fill_lvl_o    <= '0;
      fill_ap_o     <= '0;
      fill_xn_o     <= 1'b0;
      fill_pxn_o    <= 1'b0;
      fill_contig_o <= 1'b0;
      fill_ng_o     <= 1'b0;
      fill_secure_o <= 1'b0;
      fill_sh_o     <= '0;
      fill_attr_o   <= '0;
    end else begin
      fill_valid_o  <= 1'b0;
      fault_valid_o <= 1'b0;
      if (rsp_ok && kind != K_TABLE) begin
        if (kind == K_INV || !d[10]) begin
          fault_valid_o <= 1'b1;
          fault_af_o    <= (kind != K_INV);
          fault_lvl_o   <= lvl_q;
        end else begin
          fill_valid_o  <= 1'b1;
          fill_oa_o     <= leaf_oa;
          fill_lvl_o    <= lvl_q;
          fill_ap_o     <= {d[7] | acc_ro, d[6] & ~acc_nouser};
          fill_xn_o     <= d[54] | acc_xn;
          fill_pxn_o    <= d[53] | acc_pxn;
          fill_contig_o <= d[52];
          fill_ng_o     <= d[11] & ~high_el_q;
          fill_secure_o <= secure_q & ~acc_ns & ~d[5];
          fill_sh_o     <= d[9:8];
          fill_attr_o   <= d[4:2];
        end
      end
    end
  end

  assert_req_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  assert_l0_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ok && lvl_q == '0 && d[1:0] == 2'b01) |=> (fault_valid_o && !fault_af_o && fault_lvl_o == '0));
  assert_af_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ok && (kind == K_BLOCK || kind == K_PAGE) && !d[10]) |=> (fault_valid_o && fault_af_o && !fill_valid_o));
  assert_global_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o && high_el_q) |-> !fill_ng_o);
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_o && fault_valid_o));
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o || fault_valid_o) |-> !busy_o);
  assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o || fault_valid_o) |=> !(fill_valid_o || fault_valid_o));
endmodule

// File: tb/ptw_long4k_tb.sv
module ptw_long4k_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        flt;
    logic        af;
    logic [1:0]  lvl;
    logic [47:0] oa;
    logic [1:0]  ap;
    logic        xn;
    logic        pxn;
    logic        contig;
    logic        ng;
    logic        sec;
    logic [1:0]  sh;
    logic [2:0]  attr;
  } res_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  start_lvl = '0;
  logic [47:0] va = '0, tbase = '0;
  logic        sec = 1'b0, hiel = 1'b0;
  logic        busy, req_v, req_rdy = 1'b1;
  logic [47:0] req_a;
  logic        rsp_v = 1'b0;
  logic [63:0] rsp_d = '0;
  logic        f_v, f_ctg, f_ng, f_sec, f_xn, f_pxn, x_v, x_af;
  logic [47:0] f_oa;
  logic [1:0]  f_lvl, f_ap, f_sh, x_lvl;
  logic [2:0]  f_attr;

  ptw_long4k u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_lvl_i(start_lvl),
    .va_i(va), .tbl_base_i(tbase), .secure_i(sec), .high_el_i(hiel),
    .busy_o(busy), .mem_req_valid_o(req_v), .mem_req_ready_i(req_rdy),
    .mem_req_addr_o(req_a), .mem_rsp_valid_i(rsp_v), .mem_rsp_data_i(rsp_d),
    .fill_valid_o(f_v), .fill_oa_o(f_oa), .fill_lvl_o(f_lvl), .fill_ap_o(f_ap),
    .fill_xn_o(f_xn), .fill_pxn_o(f_pxn), .fill_contig_o(f_ctg), .fill_ng_o(f_ng),
    .fill_secure_o(f_sec), .fill_sh_o(f_sh), .fill_attr_o(f_attr),
    .fault_valid_o(x_v), .fault_af_o(x_af), .fault_lvl_o(x_lvl)
  );

  logic [63:0] mem [logic [47:0]];
  int          rd_total = 0;
  logic [47:0] last_addr = '0;
  int          n_chk = 0, n_fail = 0;
  bit          stall_en = 1'b0;
  res_t        got;
  int          pulses, reads;

  function automatic logic [63:0] mem_rd(logic [47:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  function automatic logic [47:0] idx_addr(logic [47:0] b, logic [47:0] v, int lvl);
    return b | (((v >> (12 + 9*(3-lvl))) & 48'h1FF) << 3);
  endfunction

  // independent model of a walk over the bench memory
  function automatic res_t ref_walk(logic [47:0] v, logic [47:0] b0, int l0, bit s, bit h,
                                    output int nrd);
    res_t r; logic [47:0] b, mask; int lvl, n; logic [63:0] d;
    bit ns, ro, nu, xn, pxn, leaf;
    r = '0; b = {b0[47:12], 12'h0}; lvl = l0; nrd = 0;
    ns = 0; ro = 0; nu = 0; xn = 0; pxn = 0;
    for (int i = 0; i < 4; i++) begin
      d = mem_rd(idx_addr(b, v, lvl)); nrd++;
      if (d[1:0] == 2'b11 && lvl < 3) begin
        ns |= d[63]; ro |= d[62]; nu |= d[61]; xn |= d[60]; pxn |= d[59];
        b = {d[47:12], 12'h0}; lvl++;
      end else begin
        leaf = (d[1:0] == 2'b11) || (d[1:0] == 2'b01 && (lvl == 1 || lvl == 2));
        r.lvl = 2'(lvl);
        if (!leaf) begin r.flt = 1; return r; end
        if (!d[10]) begin r.flt = 1; r.af = 1; return r; end
        n = (lvl == 1) ? 30 : (lvl == 2) ? 21 : 12;
        mask = (48'h1 << n) - 48'h1;
        r.oa = (d[47:0] & ~mask) | (v & mask);
        r.ap = {d[7] | ro, d[6] & ~nu};
        r.xn = d[54] | xn; r.pxn = d[53] | pxn; r.contig = d[52];
        r.ng = d[11] & ~h; r.sec = s & ~ns & ~d[5];
        r.sh = d[9:8]; r.attr = d[4:2];
        return r;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory responder: one cycle after an accepted request
  always @(posedge clk) begin
    rsp_v <= 1'b0;
    if (req_v && req_rdy) begin
      rsp_v     <= 1'b1;
      rsp_d     <= mem_rd(req_a);
      rd_total  <= rd_total + 1;
      last_addr <= req_a;
    end
  end

  initial forever begin
    @(negedge clk);
    req_rdy = stall_en ? (($urandom % 4) != 0) : 1'b1;
  end

  task automatic run_walk(input logic [47:0] v, input logic [47:0] b, input int l,
                          input bit s, input bit h, input bit extra);
    int rd0, seen, tail;
    rd0 = rd_total; pulses = 0; seen = 0; tail = 0; got = '0;
    @(negedge clk);
    va = v; tbase = b; start_lvl = 2'(l); sec = s; hiel = h; start = 1'b1;
    for (int i = 0; i < 300 && tail < 4; i++) begin
      @(negedge clk);
      if (f_v || x_v) begin
        pulses++;
        if (!seen) begin
          got.flt = x_v; got.af = x_af; got.lvl = x_v ? x_lvl : f_lvl;
          got.oa = f_oa; got.ap = f_ap; got.xn = f_xn; got.pxn = f_pxn;
          got.contig = f_ctg; got.ng = f_ng; got.sec = f_sec;
          got.sh = f_sh; got.attr = f_attr;
        end
        seen = 1;
      end
      if (seen) tail++;
      if (i == 0 && extra) begin
        start = 1'b1; va = ~v; start_lvl = 2'd3;   // must be ignored while busy
      end else start = 1'b0;
    end
    start = 1'b0;
    if (!seen) chk(1'b0, "R9 walk timed out", 0, 1);
    chk(!busy, "R9 idle after result", 64'(busy), 0);
    reads = rd_total - rd0;
  endtask

  task automatic walk_cmp(input logic [47:0] v, input logic [47:0] b, input int l,
                          input bit s, input bit h, input bit extra, input string tag);
    res_t e; int nrd;
    e = ref_walk(v, b, l, s, h, nrd);
    run_walk(v, b, l, s, h, extra);
    chk(pulses == 1, {tag, " R9 single pulse"}, 64'(pulses), 1);
    chk(reads == nrd, {tag, " R1/R10 read count"}, 64'(reads), 64'(nrd));
    chk(got.flt == e.flt, {tag, " R2 fill vs fault"}, 64'(got.flt), 64'(e.flt));
    if (e.flt) begin
      chk({got.af, got.lvl} == {e.af, e.lvl}, {tag, e.af ? " R8 af fault" : " R3 translation fault"},
          64'({got.af, got.lvl}), 64'({e.af, e.lvl}));
    end else if (!got.flt) begin
      chk({got.oa, got.lvl} == {e.oa, e.lvl}, {tag, " R4 output address"},
          64'({got.oa, got.lvl}), 64'({e.oa, e.lvl}));
      chk({got.ap, got.xn, got.pxn} == {e.ap, e.xn, e.pxn}, {tag, " R5 permissions"},
          64'({got.ap, got.xn, got.pxn}), 64'({e.ap, e.xn, e.pxn}));
      chk(got.sec == e.sec, {tag, " R6 secure"}, 64'(got.sec), 64'(e.sec));
      chk(got.ng == e.ng, {tag, " R7 non-global"}, 64'(got.ng), 64'(e.ng));
      chk({got.sh, got.attr, got.contig} == {e.sh, e.attr, e.contig}, {tag, " R12 attributes"},
          64'({got.sh, got.attr, got.contig}), 64'({e.sh, e.attr, e.contig}));
    end
  endtask

  task automatic build_random(output logic [47:0] v, output logic [47:0] b, output int l);
    logic [47:0] cur, nb; logic [63:0] e; int lvl;
    mem.delete();
    v = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    b = {8'hF0, 28'($urandom), 12'h0};
    l = $urandom % 4;
    cur = b; lvl = l;
    for (int i = 0; i < 4; i++) begin
      e = {$urandom, $urandom};
      if (lvl < 3 && ($urandom % 10) < 7) begin
        nb = {8'(lvl + 1), 28'($urandom), 12'h0};
        e[63:59] = 5'($urandom & $urandom);
        e[47:12] = nb[47:12]; e[1:0] = 2'b11;
        mem[idx_addr(cur, v, lvl)] = e;
        cur = nb; lvl++;
      end else begin
        if (($urandom % 10) < 7) e[1:0] = (lvl == 3) ? 2'b11 : 2'b01;
        e[10] = (($urandom % 8) != 0);
        mem[idx_addr(cur, v, lvl)] = e;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] v, b, a0, a1, a2;
    int l;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({busy, req_v, f_v, x_v} == 4'b0, "R11 reset outputs", 64'({busy, req_v, f_v, x_v}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R10 literal 1 GB block at start level 1
    mem.delete();
    mem[48'h1008] = 64'h0000_00C0_0000_0401;
    run_walk(48'h0000_4012_3456, 48'h1000, 1, 1'b0, 1'b0, 1'b0);
    chk(!got.flt && got.oa == 48'h00C0_0012_3456 && got.lvl == 2'd1, "R4 1GB block oa",
        64'(got.oa), 64'h00C0_0012_3456);

    // R3 block code at level 0
    mem.delete();
    a0 = idx_addr(48'h10000, 48'h0123_4567_89AB, 0);
    mem[a0] = 64'h0000_0000_4000_0401;
    walk_cmp(48'h0123_4567_89AB, 48'h10000, 0, 1'b0, 1'b0, 1'b0, "dir-l0blk");
    chk(got.flt && !got.af && got.lvl == 2'd0, "R3 block at level 0 faults", 64'({got.af, got.lvl}), 0);

    // R5 R6 R12 restrictions tighten a permissive 2 MB leaf
    v = 48'h0123_4567_89AB;
    mem.delete();
    a0 = idx_addr(48'h10000, v, 0); a1 = idx_addr(48'h20000, v, 1); a2 = idx_addr(48'h30000, v, 2);
    mem[a0] = 64'h1000_0000_0002_0003;           // table, XNTable
    mem[a1] = 64'hE000_0000_0003_0003;           // table, NSTable + APTable=11
    mem[a2] = 64'h0000_0000_4000_0755;           // block, AF, sh=3, ap=01, attr=5
    walk_cmp(v, 48'h10000, 0, 1'b1, 1'b0, 1'b0, "dir-restrict");
    chk(got.oa == 48'h0000_4007_89AB && got.lvl == 2'd2, "R4 2MB block oa", 64'(got.oa), 48'h0000_4007_89AB);
    chk(got.ap == 2'b10 && got.xn && !got.pxn, "R5 table restrictions applied",
        64'({got.ap, got.xn, got.pxn}), 64'({2'b10, 1'b1, 1'b0}));
    chk(!got.sec, "R6 NSTable forces non-secure", 64'(got.sec), 0);
    chk(got.sh == 2'd3 && got.attr == 3'd5, "R12 sh/attr fields", 64'({got.sh, got.attr}), 64'({2'd3, 3'd5}));

    // R3 block code at level 3 after full chain
    mem[a2] = 64'h0000_0000_0005_0003;
    mem[idx_addr(48'h50000, v, 3)] = 64'h0000_0000_7000_0401;
    walk_cmp(v, 48'h10000, 0, 1'b0, 1'b0, 1'b0, "dir-l3blk");
    chk(got.flt && !got.af && got.lvl == 2'd3, "R3 block at level 3 faults", 64'({got.af, got.lvl}), 3);

    // R2 page at level 3 with AF set
    mem[idx_addr(48'h50000, v, 3)] = 64'h0000_0000_7000_0403;
    walk_cmp(v, 48'h10000, 0, 1'b1, 1'b0, 1'b0, "dir-l3page");
    chk(!got.flt && got.oa == 48'h0000_7000_09AB && got.lvl == 2'd3, "R2 level-3 page",
        64'(got.oa), 48'h0000_7000_09AB);

    // R8 R10 start at level 3, AF clear
    mem.delete();
    v = 48'h1234_5678_9ABC;
    mem[48'h5000 | (((v >> 12) & 48'h1FF) << 3)] = 64'h0000_0000_8000_0003;
    walk_cmp(v, 48'h5000, 3, 1'b0, 1'b0, 1'b0, "dir-af");
    chk(got.flt && got.af && got.lvl == 2'd3, "R8 access flag fault", 64'({got.af, got.lvl}), 64'({1'b1, 2'd3}));
    chk(reads == 1 && last_addr == (48'h5000 | (((v >> 12) & 48'h1FF) << 3)), "R10 R1 single level-3 read",
        64'(last_addr), 64'(48'h5000 | (((v >> 12) & 48'h1FF) << 3)));

    // R7 forced global
    mem.delete();
    mem[idx_addr(48'h9000, v, 2)] = 64'h0000_0000_0020_0C01;
    walk_cmp(v, 48'h9000, 2, 1'b0, 1'b1, 1'b0, "dir-hiel");
    chk(!got.ng, "R7 high level forces global", 64'(got.ng), 0);
    walk_cmp(v, 48'h9000, 2, 1'b0, 1'b0, 1'b0, "dir-lowel");
    chk(got.ng, "R7 nG honoured", 64'(got.ng), 1);

    // R3 reserved codes 0 and 2 at level 1
    mem.delete();
    mem[idx_addr(48'h9000, v, 1)] = 64'h0000_0000_4000_0402;
    walk_cmp(v, 48'h9000, 1, 1'b0, 1'b0, 1'b0, "dir-code2");
    chk(got.flt && got.lvl == 2'd1, "R3 code 2 faults", 64'(got.lvl), 1);
    mem[idx_addr(48'h9000, v, 1)] = 64'h0000_0000_4000_0400;
    walk_cmp(v, 48'h9000, 1, 1'b0, 1'b0, 1'b0, "dir-code0");
    chk(got.flt && got.lvl == 2'd1, "R3 code 0 faults", 64'(got.lvl), 1);

    // R9 start while busy ignored
    stall_en = 1'b1;
    build_random(v, b, l);
    walk_cmp(v, b, l, 1'b1, 1'b0, 1'b1, "dir-restart R9");

    // random walks with request stalls
    for (int k = 0; k < 300; k++) begin
      build_random(v, b, l);
      walk_cmp(v, b, l, 1'($urandom), 1'($urandom), 1'($urandom % 8 == 0), "rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule